// File: doc/BRIEF.md
# Open-Page Read Scheduler with Hit-First Reordering

This block accepts read requests for a multi-bank SDRAM device and turns them into a stream of bank commands, at most one per cycle. Requests wait in a small queue. The block records which row, if any, is held open in every bank. Requests whose row is already open jump ahead of older requests that would need a row change. This keeps the data bus busy with cheap column reads and defers the costly close-and-open sequences.

Each cycle, one queued request is chosen as the current candidate. The block works out the single next command that the candidate needs: a precharge, an activate or a read. That command goes out only when the matching external permission input is high. The permission inputs carry all device timing legality, so the block contains no timing counters of its own apart from the data-burst window. After a read, the row is left open.

Top module: `rowhit_sched`

## Requirements
- R1: After reset there is no command (`cmd_op`=0), no burst beat, `req_full` is low, and every bank counts as closed, so the first request to any bank begins with an activate.
- R2: A queued request whose row is open in its bank is served before any older request that would need a row change.
- R3: Among several row-hit requests the oldest goes first. When no row hit is queued, the oldest request overall is the candidate.
- R4: A row-hit request is served by a single READ that carries its bank, row and column. The request leaves the queue when that READ issues.
- R5: A request to a bank that has a different row open is served by PRECHARGE of that bank, then ACTIVATE of the new row, then READ.
- R6: A request to a closed bank is served by ACTIVATE and then READ, with no PRECHARGE.
- R7: A row stays open after its READ, so a later request to the same row needs only a READ.
- R8: At most one command issues per cycle. The candidate's next command waits while its permission (`may_pre`, `may_act` or `may_rd`) is low, and no other request's command is issued in its place.
- R9: Each READ produces BL beats on consecutive cycles with `beat_idx` counting 0 to BL-1. The next READ's first beat comes no earlier than the cycle after the previous READ's last beat, so back-to-back READs are exactly BL cycles apart.
- R10: `req_full` is high exactly when DEPTH requests are pending. A request offered while `req_full` is high is dropped and never served.
- R11: The command encoding is `cmd_op` 0 = none, 1 = PRECHARGE, 2 = ACTIVATE, 3 = READ. A command is visible on the outputs in the cycle after the cycle in which it was chosen, and a READ's first beat appears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered this cycle |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_full | output | 1 | Queue holds DEPTH requests; offers are dropped |
| may_pre | input | 1 | PRECHARGE may issue this cycle |
| may_act | input | 1 | ACTIVATE may issue this cycle |
| may_rd | input | 1 | READ may issue this cycle |
| cmd_op | output | 2 | Command code (0 none, 1 PRE, 2 ACT, 3 READ) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for ACTIVATE and READ |
| cmd_col | output | COL_W | Column for READ |
| beat_valid | output | 1 | A burst beat is in progress |
| beat_idx | output | BEAT_W | Beat number within the burst |

## Verification
The bench goes after four kinds of error. The first is a newer row hit stuck behind an older miss, which shows up as an ACTIVATE or PRECHARGE appearing before the expected READ. The second is the wrong choice among several hits or several misses, which shows up as columns read in non-arrival order. The third is closing rows after a READ or treating an empty bank as open, which shows up as extra or missing PRECHARGE and ACTIVATE commands. The fourth is an offer while full that sneaks into the queue, or a READ issued into a busy burst window, which shows up as a gap or overlap in the beat stream. A cycle-accurate model runs alongside long random traffic with permissions that are often withheld. It compares every command, every beat and the full flag cycle by cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PRE  = 2'd1,
    OP_ACT  = 2'd2,
    OP_RD   = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/sched_queue.sv
// Pending-request store with rank ages: age = number of younger valid entries.
module sched_queue #(
  parameter int DEPTH  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 3,
  parameter int IDX_W  = 2,
  parameter int AGE_W  = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              push,
  input  logic [BANK_W-1:0]                 push_bank,
  input  logic [ROW_W-1:0]                  push_row,
  input  logic [COL_W-1:0]                  push_col,
  input  logic                              pop,
  input  logic [IDX_W-1:0]                  pop_idx,
  output logic [DEPTH-1:0]                  e_valid,
  output logic [DEPTH-1:0][BANK_W-1:0]      e_bank,
  output logic [DEPTH-1:0][ROW_W-1:0]       e_row,
  output logic [DEPTH-1:0][COL_W-1:0]       e_col,
  output logic [DEPTH-1:0][AGE_W-1:0]       e_age,
  output logic                              full
);

  logic [IDX_W-1:0] free_idx;

  assign full = &e_valid;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!e_valid[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && (pop_idx == IDX_W'(i))) begin
          e_valid[i] <= 1'b0;
        end else if (e_valid[i]) begin
          e_age[i] <= e_age[i] + AGE_W'(push)
                      - AGE_W'(pop && (e_age[i] > e_age[pop_idx]));
        end
      end
      if (push) begin
        e_valid[free_idx] <= 1'b1;
        e_age[free_idx]   <= '0;
      end
    end
  end

  // Payload storage: no reset, written only on push.
  always_ff @(posedge clk) begin
    if (push) begin
      e_bank[free_idx] <= push_bank;
      e_row[free_idx]  <= push_row;
      e_col[free_idx]  <= push_col;
    end
  end

  // R10: the top never pushes into a full queue.
  a_r10_no_push_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);

  // R3: ages rank the entries; an age never reaches the number of valid entries.
  for (genvar g = 0; g < DEPTH; g++) begin : g_age_chk
    a_r3_age_rank: assert property (@(posedge clk) disable iff (rst)
      e_valid[g] |-> (32'(e_age[g]) < $countones(e_valid)));
  end

endmodule

// File: rtl/sched_pick.sv
// Candidate selection: oldest row hit, else oldest entry.
module sched_pick #(
  parameter int DEPTH     = 4,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 2,
  parameter int IDX_W     = 2,
  parameter int AGE_W     = 2
) (
  input  logic [DEPTH-1:0]                  e_valid,
  input  logic [DEPTH-1:0][BANK_W-1:0]      e_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]       e_row,
  input  logic [DEPTH-1:0][AGE_W-1:0]       e_age,
  input  logic [NUM_BANKS-1:0]              open_v,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]   open_row,
  output logic                              sel_any,
  output logic [IDX_W-1:0]                  sel_idx,
  output logic                              sel_hit,
  output logic                              sel_open
);

  logic [DEPTH-1:0] is_hit;
  logic [IDX_W-1:0] hit_idx, old_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      is_hit[i] = e_valid[i] && open_v[e_bank[i]] &&
                  (open_row[e_bank[i]] == e_row[i]);
    end
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_any = 1'b0;
    hit_idx = '0;
    old_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (is_hit[i] && (!sel_hit || (e_age[i] > e_age[hit_idx]))) begin
        sel_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (e_valid[i] && (!sel_any || (e_age[i] > e_age[old_idx]))) begin
        sel_any = 1'b1;
        old_idx = IDX_W'(i);
      end
    end
    sel_idx  = sel_hit ? hit_idx : old_idx;
    sel_open = open_v[e_bank[sel_idx]];
  end

endmodule

// File: rtl/sched_banks.sv
// Open-row tracker, one entry per bank.
module sched_banks #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              do_pre,
  input  logic                              do_act,
  input  logic [BANK_W-1:0]                 bank,
  input  logic [ROW_W-1:0]                  row,
  output logic [NUM_BANKS-1:0]              open_v,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]   open_row
);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_v   <= '0;
      open_row <= '0;
    end else if (do_pre) begin
      open_v[bank] <= 1'b0;
    end else if (do_act) begin
      open_v[bank]   <= 1'b1;
      open_row[bank] <= row;
    end
  end

  // R5: a precharge only ever targets an open bank.
  a_r5_pre_open: assert property (@(posedge clk) disable iff (rst)
    do_pre |-> open_v[bank]);
  // R6: an activate only ever targets a closed bank.
  a_r6_act_closed: assert property (@(posedge clk) disable iff (rst)
    do_act |-> !open_v[bank]);

endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
  import sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 2,
  parameter int COL_W     = 3,
  parameter int DEPTH     = 4,
  parameter int BL        = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BEAT_W   = (BL > 1) ? $clog2(BL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_full,
  input  logic              may_pre,
  input  logic              may_act,
  input  logic              may_rd,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat_idx
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int AGE_W = IDX_W;
  localparam int CNT_W = $clog2(BL + 1);

  logic [DEPTH-1:0]                 e_valid;
  logic [DEPTH-1:0][BANK_W-1:0]     e_bank;
  logic [DEPTH-1:0][ROW_W-1:0]      e_row;
  logic [DEPTH-1:0][COL_W-1:0]      e_col;
  logic [DEPTH-1:0][AGE_W-1:0]      e_age;
  logic [NUM_BANKS-1:0]             open_v;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row;
  logic                             sel_any, sel_hit, sel_open;
  logic [IDX_W-1:0]                 sel_idx;
  logic                             push, do_pre, do_act, do_rd;
  logic [CNT_W-1:0]                 burst_cnt;
  logic [BANK_W-1:0]                s_bank;
  logic [ROW_W-1:0]                 s_row;
  logic [COL_W-1:0]                 s_col;

  assign push = req_valid && !req_full;

  sched_queue #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .IDX_W(IDX_W), .AGE_W(AGE_W)
  ) u_queue (
    .clk(clk), .rst(rst),
    .push(push), .push_bank(req_bank), .push_row(req_row), .push_col(req_col),
    .pop(do_rd), .pop_idx(sel_idx),
    .e_valid(e_valid), .e_bank(e_bank), .e_row(e_row), .e_col(e_col),
    .e_age(e_age), .full(req_full)
  );

  sched_pick #(
    .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .IDX_W(IDX_W), .AGE_W(AGE_W)
  ) u_pick (
    .e_valid(e_valid), .e_bank(e_bank), .e_row(e_row), .e_age(e_age),
    .open_v(open_v), .open_row(open_row),
    .sel_any(sel_any), .sel_idx(sel_idx), .sel_hit(sel_hit), .sel_open(sel_open)
  );

  assign s_bank = e_bank[sel_idx];
  assign s_row  = e_row[sel_idx];
  assign s_col  = e_col[sel_idx];

  // One command per cycle, for the candidate only (R8).
  assign do_rd  = sel_any && sel_hit && may_rd && (burst_cnt <= CNT_W'(1));
  assign do_pre = sel_any && !sel_hit && sel_open && may_pre;
  assign do_act = sel_any && !sel_open && may_act;

  sched_banks #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_banks (
    .clk(clk), .rst(rst), .do_pre(do_pre), .do_act(do_act),
    .bank(s_bank), .row(s_row), .open_v(open_v), .open_row(open_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_op    <= OP_NONE;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      burst_cnt <= '0;
    end else begin
      cmd_bank <= s_bank;
      cmd_row  <= s_row;
      cmd_col  <= s_col;
      if (do_rd)       cmd_op <= OP_RD;
      else if (do_act) cmd_op <= OP_ACT;
      else if (do_pre) cmd_op <= OP_PRE;
      else             cmd_op <= OP_NONE;
      if (do_rd)                 burst_cnt <= CNT_W'(BL);
      else if (burst_cnt != '0)  burst_cnt <= burst_cnt - CNT_W'(1);
    end
  end

  assign beat_valid = (burst_cnt != '0);
  assign beat_idx   = BEAT_W'(CNT_W'(BL) - burst_cnt);

  // R11: a READ on the outputs coincides with beat 0 of its burst.
  a_r11_read_beat0: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_RD) |-> (beat_valid && (beat_idx == '0)));
  // R8: withheld permissions stop the matching command.
  a_r8_rd_wait: assert property (@(posedge clk) disable iff (rst)
    !may_rd |=> (cmd_op != OP_RD));
  a_r8_act_wait: assert property (@(posedge clk) disable iff (rst)
    !may_act |=> (cmd_op != OP_ACT));
  // R9: two READs are never on adjacent cycles when bursts are longer than one.
  if (BL > 1) begin : g_spacing
    a_r9_read_spacing: assert property (@(posedge clk) disable iff (rst)
      (cmd_op == OP_RD) |=> (cmd_op != OP_RD));
  end

endmodule

// File: tb/test_rowhit_sched.sv
module test_rowhit_sched;
  localparam int NB = 4, RW = 2, CW = 3, D = 4, BL = 4;
  localparam int BW = 2, EW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic may_pre = 1'b1, may_act = 1'b1, may_rd = 1'b1;
  logic req_full, beat_valid;
  logic [1:0] cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic [EW-1:0] beat_idx;

  rowhit_sched #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .DEPTH(D), .BL(BL)) i_rowhit_sched (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_full(req_full),
    .may_pre(may_pre), .may_act(may_act), .may_rd(may_rd),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .beat_valid(beat_valid), .beat_idx(beat_idx)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  // reference model state
  bit m_v[D];
  int m_b[D], m_r[D], m_c[D], m_s[D];
  bit m_ov[NB];
  int m_or[NB];
  int m_cnt = 0, m_seq = 0;
  // command log from the outputs
  int l_n = 0;
  int l_op[64], l_bank[64], l_row[64], l_col[64], l_cyc[64];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int enc(input int op, input int b, input int r, input int c);
    case (op)
      1: return op * 4096 + b * 256;
      2: return op * 4096 + b * 256 + r * 16;
      3: return op * 4096 + b * 256 + r * 16 + c;
      default: return 0;
    endcase
  endfunction

  // One clock cycle: predict, let the edge pass, compare, advance the model.
  task automatic step();
    int sel = -1, cnt_v = 0, slot = -1, exp_op = 0;
    bit hit = 0, full_now;
    string tag;
    for (int i = 0; i < D; i++) if (m_v[i]) cnt_v++;
    full_now = (cnt_v == D);
    for (int i = 0; i < D; i++)
      if (m_v[i] && m_ov[m_b[i]] && m_or[m_b[i]] == m_r[i] && (!hit || m_s[i] < m_s[sel])) begin
        sel = i; hit = 1;
      end
    if (!hit)
      for (int i = 0; i < D; i++)
        if (m_v[i] && (sel < 0 || m_s[i] < m_s[sel])) sel = i;
    if (sel >= 0) begin
      if (hit) begin if (may_rd && m_cnt <= 1) exp_op = 3; end
      else if (m_ov[m_b[sel]]) begin if (may_pre) exp_op = 1; end
      else if (may_act) exp_op = 2;
    end
    if (req_valid && !full_now)
      for (int i = D - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    @(posedge clk); #1;
    tag = (exp_op == 3) ? "R4" : (exp_op == 1) ? "R5" : (exp_op == 2) ? "R6" : "R8";
    chk(enc(int'(cmd_op), int'(cmd_bank), int'(cmd_row), int'(cmd_col)) ==
        ((sel >= 0) ? enc(exp_op, m_b[sel], m_r[sel], m_c[sel]) : 0), tag, "command",
        enc(int'(cmd_op), int'(cmd_bank), int'(cmd_row), int'(cmd_col)),
        (sel >= 0) ? enc(exp_op, m_b[sel], m_r[sel], m_c[sel]) : 0);
    if (cmd_op != 2'd0 && l_n < 64) begin
      l_op[l_n] = int'(cmd_op); l_bank[l_n] = int'(cmd_bank); l_row[l_n] = int'(cmd_row);
      l_col[l_n] = int'(cmd_col); l_cyc[l_n] = cyc; l_n++;
    end
    m_cnt = (exp_op == 3) ? BL : (m_cnt > 0 ? m_cnt - 1 : 0);
    chk(beat_valid == (m_cnt != 0) && (m_cnt == 0 || int'(beat_idx) == BL - m_cnt),
        "R9", "beat", int'(beat_valid) * 16 + int'(beat_idx),
        int'(m_cnt != 0) * 16 + (m_cnt != 0 ? BL - m_cnt : int'(beat_idx)));
    if (exp_op == 1) m_ov[m_b[sel]] = 0;
    if (exp_op == 2) begin m_ov[m_b[sel]] = 1; m_or[m_b[sel]] = m_r[sel]; end
    if (exp_op == 3) m_v[sel] = 0;
    if (slot >= 0) begin
      m_v[slot] = 1; m_b[slot] = int'(req_bank); m_r[slot] = int'(req_row);
      m_c[slot] = int'(req_col); m_s[slot] = m_seq; m_seq++;
    end
    cnt_v = 0;
    for (int i = 0; i < D; i++) if (m_v[i]) cnt_v++;
    chk(req_full == (cnt_v == D), "R10", "full", int'(req_full), int'(cnt_v == D));
    @(negedge clk);
  endtask

  task automatic offer(input int b, input int r, input int c);
    req_valid = 1'b1; req_bank = BW'(b); req_row = RW'(r); req_col = CW'(c);
    step();
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic perm(input bit p, input bit a, input bit r);
    may_pre = p; may_act = a; may_rd = r;
  endtask

  initial begin
    for (int i = 0; i < D; i++) m_v[i] = 0;
    for (int i = 0; i < NB; i++) begin m_ov[i] = 0; m_or[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(cmd_op == 2'd0 && !beat_valid && !req_full, "R1", "reset state",
        int'(cmd_op) + int'(beat_valid) * 4 + int'(req_full) * 8, 0);

    // closed bank: ACT then READ; codes 2 and 3
    l_n = 0; offer(0, 1, 2); idle(6);
    chk(l_n == 2 && l_op[0] == 2 && l_op[1] == 3, "R6", "closed bank sequence", l_n * 100 + l_op[0] * 10 + l_op[1], 223);
    chk(l_op[0] == 2 && l_bank[0] == 0 && l_row[0] == 1, "R1", "first access activates", l_op[0], 2);
    chk(l_op[1] == 3 && l_col[1] == 2 && l_cyc[1] == l_cyc[0] + 1, "R11", "read code and timing", l_cyc[1] - l_cyc[0], 1);

    // same row again: READ only
    l_n = 0; offer(0, 1, 5); idle(6);
    chk(l_n == 1 && l_op[0] == 3 && l_col[0] == 5, "R7", "row left open", l_n * 10 + l_op[0], 13);

    // other row in open bank: PRE, ACT, READ
    l_n = 0; offer(0, 2, 0); idle(8);
    chk(l_n == 3 && l_op[0] == 1 && l_op[1] == 2 && l_op[2] == 3 && l_row[1] == 2, "R5",
        "row change sequence", l_op[0] * 100 + l_op[1] * 10 + l_op[2], 123);

    // newer hit overtakes older miss
    l_n = 0; perm(0, 0, 0); offer(1, 3, 1); offer(0, 2, 4); perm(1, 1, 1); idle(12);
    chk(l_n == 3 && l_op[0] == 3 && l_bank[0] == 0 && l_col[0] == 4, "R2", "hit first",
        l_op[0] * 10 + l_bank[0], 30);

    // several hits: arrival order; back-to-back READs BL apart
    l_n = 0; perm(0, 0, 0); offer(0, 2, 6); offer(1, 3, 7); offer(0, 2, 3); perm(1, 1, 1); idle(16);
    chk(l_n == 3 && l_col[0] == 6 && l_col[1] == 7 && l_col[2] == 3, "R3", "oldest hit first",
        l_col[0] * 100 + l_col[1] * 10 + l_col[2], 673);
    chk(l_cyc[1] - l_cyc[0] == BL && l_cyc[2] - l_cyc[1] == BL, "R9", "read spacing",
        l_cyc[1] - l_cyc[0], BL);

    // no hits: oldest miss first
    l_n = 0; perm(0, 0, 0); offer(2, 0, 1); offer(3, 1, 2); perm(1, 1, 1); idle(14);
    chk(l_n == 4 && l_op[0] == 2 && l_bank[0] == 2, "R3", "oldest miss first", l_bank[0], 2);

    // withheld permission blocks everything
    l_n = 0; perm(0, 1, 1); offer(3, 2, 0); idle(8);
    chk(l_n == 0, "R8", "precharge withheld", l_n, 0);
    perm(1, 1, 1); idle(8);
    chk(l_n == 3 && l_op[0] == 1, "R8", "precharge released", l_op[0], 1);

    // full queue drops the fifth offer
    l_n = 0; perm(0, 0, 0);
    offer(0, 2, 0); offer(0, 2, 1); offer(0, 2, 2); offer(0, 2, 3);
    chk(req_full == 1'b1, "R10", "full at depth", int'(req_full), 1);
    offer(1, 0, 7); perm(1, 1, 1); idle(30);
    begin
      bit seen7 = 0;
      for (int i = 0; i < l_n; i++) if (l_col[i] == 7) seen7 = 1;
      chk(l_n == 4 && !seen7, "R10", "dropped offer never served", l_n + int'(seen7) * 10, 4);
    end

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      req_valid = ($urandom % 2) == 0;
      req_bank = BW'($urandom % NB); req_row = RW'($urandom % 4); req_col = CW'($urandom % 8);
      perm(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0);
      l_n = 0;
      step();
    end
    req_valid = 1'b0; perm(1, 1, 1); idle(40);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule